// File: doc/BRIEF.md
# Sampling Converter Digital Control Model

This block is the synthesizable digital control portion of a 12-bit sampling converter, built to stand in for a real converter in system testbenches. A falling edge on the active-low convert request captures the value on a test input port, raises the busy flag and starts a conversion timer. The timer takes the place of the successive-approximation search. When the timer expires the result is loaded into a 16-bit output shifter, and an external serial clock then reads it out MSB first.

The model runs on its own internal clock. The convert request and the serial clock come in asynchronously and each passes through a two-stage synchroniser before its edges are detected. If the convert request is still low when a conversion ends, the model goes to sleep. A later rising edge of the request starts a timed wake-up, and only after it completes is a new conversion accepted. A request edge that arrives while a conversion is running, or while the model is waking up, is dropped and noted in a sticky flag.

The controller has four states: IDLE (waiting for a request), CONV (timer running, busy high), SLEEP (powered down) and WAKE (wake-up timer running). The transitions are:
- IDLE→CONV on an accepted falling edge.
- CONV→IDLE when the timer expires with the request high.
- CONV→SLEEP when the timer expires with the request low.
- SLEEP→WAKE on a rising edge.
- WAKE→IDLE when the wake-up timer expires.

Top module: `adc_ctrl_model`

## Requirements
- R1: In IDLE, a synchronised falling edge of `conv_req_n` captures `sample_in`. Changes on `sample_in` after that edge do not alter the word that is read out.
- R2: `conv_busy` stays high for exactly CONV_CYCLES clock cycles per accepted conversion and is low in every other state.
- R3: The output word is 16 bits, sent MSB first. It is four zero bits followed by the captured 12-bit value in straight binary, bit 11 first.
- R4: On the clock edge where `conv_busy` falls, `ser_oe` goes high and `ser_out` carries the first (zero) bit. `ser_oe` rises at no other time.
- R5: After each synchronised falling edge of `ser_clk`, the current bit stays on `ser_out` for HOLD_CYCLES cycles before the next bit appears.
- R6: After the sixteenth falling edge of `ser_clk`, `ser_out` is held for the hold interval and then `ser_oe` goes low. `ser_oe` is low whenever `conv_busy` is high.
- R7: If `conv_req_n` is low when a conversion ends, the model enters SLEEP. A rising edge starts a wake-up of WAKE_CYCLES cycles. A falling edge during the wake-up starts nothing; a falling edge after the wake-up starts a conversion.
- R8: If `conv_req_n` is high when a conversion ends, the model returns to IDLE, and the next falling edge starts a conversion at once.
- R9: A falling edge of `conv_req_n` during CONV or WAKE is ignored and sets `missed_req`. `missed_req` stays high until reset.
- R10: An accepted conversion clears the output enable and restarts the bit count. The next read-out therefore begins from the first bit even if the previous one was cut short.
- R11: While `rst_n` is low and after it is released, `conv_busy`, `ser_oe` and `missed_req` are low.
- R12: Each asynchronous input passes through two flops before edge detection, so `conv_busy` rises on the third clock edge after `conv_req_n` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset |
| conv_req_n | input | 1 | Asynchronous active-low convert request |
| ser_clk | input | 1 | Asynchronous external serial read clock |
| sample_in | input | 12 | Test value standing in for the analog input |
| conv_busy | output | 1 | High while a conversion runs |
| ser_out | output | 1 | Serial data bit (meaningful when `ser_oe` is high) |
| ser_oe | output | 1 | Drive enable for the serial data line |
| missed_req | output | 1 | Sticky flag for ignored convert requests |

## Verification
The bench builds the block with CONV_CYCLES=24, WAKE_CYCLES=16 and HOLD_CYCLES=2 in place of the multi-thousand-cycle defaults. At these values every conversion, every complete 16-bit read-out and a full sleep-and-wake sequence fit in a few hundred cycles. That makes it possible to run many random sample values and to place request edges at chosen points inside the conversion and wake-up windows. The short hold lets the bench sample `ser_oe` inside the hold window that follows the final serial clock edge.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONV  = 2'd1,
        ST_SLEEP = 2'd2,
        ST_WAKE  = 2'd3
    } ctl_state_t;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    input  logic rst_val,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= rst_val;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= rst_val;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last <= rst_val;
        else        last <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~last;
    assign fall  = ~chain[STAGES-1] & last;
endmodule

// File: rtl/ctl_fsm.sv
module ctl_fsm
    import adc_ctrl_pkg::*;
#(
    parameter int CONV_CYCLES = 2000,
    parameter int WAKE_CYCLES = 1500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_level,
    input  logic req_rise,
    input  logic req_fall,
    output logic busy,
    output logic start_ok,
    output logic conv_done,
    output logic missed
);
    localparam int MAXC = (CONV_CYCLES > WAKE_CYCLES) ? CONV_CYCLES : WAKE_CYCLES;
    localparam int TW   = $clog2(MAXC + 1);
    localparam logic [TW-1:0] CONV_LD = TW'(CONV_CYCLES - 1);
    localparam logic [TW-1:0] WAKE_LD = TW'(WAKE_CYCLES - 1);

    ctl_state_t state, nxt;
    logic [TW-1:0] cnt, cnt_nxt;
    logic miss_hit;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            missed <= 1'b0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
            if (miss_hit) missed <= 1'b1;
        end
    end

    // Next-state process
    always_comb begin
        nxt       = state;
        cnt_nxt   = cnt;
        start_ok  = 1'b0;
        conv_done = 1'b0;
        miss_hit  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_fall) begin
                    nxt      = ST_CONV;
                    cnt_nxt  = CONV_LD;
                    start_ok = 1'b1;
                end
            end
            ST_CONV: begin
                if (req_fall) miss_hit = 1'b1;
                if (cnt == '0) begin
                    conv_done = 1'b1;
                    nxt       = req_level ? ST_IDLE : ST_SLEEP;
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            ST_SLEEP: begin
                if (req_rise) begin
                    nxt     = ST_WAKE;
                    cnt_nxt = WAKE_LD;
                end
            end
            ST_WAKE: begin
                if (req_fall) miss_hit = 1'b1;
                if (cnt == '0) nxt = ST_IDLE;
                else           cnt_nxt = cnt - 1'b1;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Output process
    always_comb begin
        busy = (state == ST_CONV);
    end
endmodule

// File: rtl/serial_shifter.sv
module serial_shifter #(
    parameter int WORD_W      = 16,
    parameter int HOLD_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              sclk_fall,
    output logic              sdo,
    output logic              oe
);
    localparam int CW = $clog2(WORD_W);
    localparam int HW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST_BIT = CW'(WORD_W - 1);
    localparam logic [HW-1:0] HOLD_LD  = HW'(HOLD_CYCLES - 1);

    logic [WORD_W-1:0] word;
    logic [CW-1:0]     bit_idx;
    logic [HW-1:0]     hold_cnt;
    logic              pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word     <= '0;
            bit_idx  <= '0;
            hold_cnt <= '0;
            pend     <= 1'b0;
            oe       <= 1'b0;
        end else if (clear) begin
            bit_idx <= '0;
            pend    <= 1'b0;
            oe      <= 1'b0;
        end else if (load) begin
            word    <= load_word;
            bit_idx <= '0;
            pend    <= 1'b0;
            oe      <= 1'b1;
        end else if (pend) begin
            if (hold_cnt == '0) begin
                pend <= 1'b0;
                if (bit_idx == LAST_BIT) begin
                    oe <= 1'b0;
                end else begin
                    word    <= {word[WORD_W-2:0], 1'b0};
                    bit_idx <= bit_idx + 1'b1;
                end
            end else begin
                hold_cnt <= hold_cnt - 1'b1;
            end
        end else if (sclk_fall && oe) begin
            pend     <= 1'b1;
            hold_cnt <= HOLD_LD;
        end
    end

    assign sdo = oe & word[WORD_W-1];
endmodule

// File: rtl/adc_ctrl_model.sv
module adc_ctrl_model #(
    parameter int DATA_W      = 12,
    parameter int PAD_W       = 4,
    parameter int CONV_CYCLES = 2000,
    parameter int WAKE_CYCLES = 1500,
    parameter int HOLD_CYCLES = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_req_n,
    input  logic              ser_clk,
    input  logic [DATA_W-1:0] sample_in,
    output logic              conv_busy,
    output logic              ser_out,
    output logic              ser_oe,
    output logic              missed_req
);
    localparam int WORD_W = DATA_W + PAD_W;

    logic req_level, req_rise, req_fall;
    logic sclk_level, sclk_rise, sclk_fall;
    logic start_ok, conv_done;
    logic [DATA_W-1:0] held_q;

    edge_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk(clk), .rst_n(rst_n), .async_in(conv_req_n), .rst_val(1'b1),
        .level(req_level), .rise(req_rise), .fall(req_fall)
    );

    edge_sync #(.STAGES(SYNC_STAGES)) u_sclk_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ser_clk), .rst_val(1'b0),
        .level(sclk_level), .rise(sclk_rise), .fall(sclk_fall)
    );

    ctl_fsm #(.CONV_CYCLES(CONV_CYCLES), .WAKE_CYCLES(WAKE_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_level(req_level), .req_rise(req_rise), .req_fall(req_fall),
        .busy(conv_busy), .start_ok(start_ok), .conv_done(conv_done),
        .missed(missed_req)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        held_q <= '0;
        else if (start_ok) held_q <= sample_in;
    end

    serial_shifter #(.WORD_W(WORD_W), .HOLD_CYCLES(HOLD_CYCLES)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .clear(start_ok), .load(conv_done),
        .load_word({{PAD_W{1'b0}}, held_q}),
        .sclk_fall(sclk_fall),
        .sdo(ser_out), .oe(ser_oe)
    );

    logic unused_sclk;
    assign unused_sclk = sclk_level ^ sclk_rise;
endmodule

// File: rtl/adc_ctrl_checks.sv
module adc_ctrl_checks #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_busy,
    input logic              ser_out,
    input logic              ser_oe,
    input logic              missed_req,
    input logic [DATA_W-1:0] held_q
);
    AST_OE_LOW_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        conv_busy |-> !ser_oe); // R6

    AST_LOAD_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_busy) |-> (ser_oe && !ser_out)); // R4

    AST_OE_RISES_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_oe) |-> $fell(conv_busy)); // R4

    AST_MISSED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        missed_req |=> missed_req); // R9

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_busy && $past(conv_busy)) |-> $stable(held_q)); // R1
endmodule

bind adc_ctrl_model adc_ctrl_checks #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .conv_busy(conv_busy), .ser_out(ser_out),
    .ser_oe(ser_oe), .missed_req(missed_req), .held_q(held_q)
);

// File: tb/sim_adc_ctrl_model.sv
module sim_adc_ctrl_model;
    localparam int CONV = 24;
    localparam int WAKE = 16;
    localparam int HOLD = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_req_n = 1'b1;
    logic ser_clk = 1'b0;
    logic [11:0] sample_in = '0;
    logic conv_busy, ser_out, ser_oe, missed_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    adc_ctrl_model #(.CONV_CYCLES(CONV), .WAKE_CYCLES(WAKE), .HOLD_CYCLES(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .conv_req_n(conv_req_n), .ser_clk(ser_clk),
        .sample_in(sample_in), .conv_busy(conv_busy), .ser_out(ser_out),
        .ser_oe(ser_oe), .missed_req(missed_req)
    );

    function automatic logic [15:0] exp_word(input logic [11:0] v);
        return {4'b0000, v};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        conv_req_n = 1'b1;
        ser_clk = 1'b0;
        repeat (4) @(negedge clk);
        chk(!conv_busy && !ser_oe && !missed_req, "R11 reset outputs",
            {conv_busy, ser_oe, missed_req}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!conv_busy && !ser_oe && !missed_req, "R11 after release",
            {conv_busy, ser_oe, missed_req}, 0);
    endtask

    // Starts a conversion, checks latency and busy width; returns at the busy-fall negedge.
    task automatic do_conv(input logic [11:0] v, input bit keep_low, input bit extra_fall);
        int lat = 0;
        int len = 0;
        sample_in  = v;
        conv_req_n = 1'b0;
        while (!conv_busy && lat < 12) begin
            @(negedge clk);
            lat++;
            if (lat == 2 && !keep_low) conv_req_n = 1'b1;
        end
        chk(lat == 3, "R12 busy latency", lat, 3);
        sample_in = 12'($urandom);
        while (conv_busy && len < 4 * CONV) begin
            @(negedge clk);
            len++;
            if (extra_fall && len == 6) conv_req_n = 1'b0;
            if (extra_fall && len == 10) conv_req_n = 1'b1;
        end
        chk(len == CONV, "R2 busy width", len, CONV);
    endtask

    task automatic read_word(input int nbits, output logic [15:0] w);
        w = '0;
        chk(ser_oe == 1'b1 && ser_out == 1'b0, "R4 first bit at busy fall", {ser_oe, ser_out}, 2);
        for (int i = 0; i < nbits; i++) begin
            w[15-i] = ser_out;
            ser_clk = 1'b1;
            repeat (8) @(negedge clk);
            ser_clk = 1'b0;
            repeat (4) @(negedge clk);
            if (i == 15) chk(ser_oe == 1'b1, "R5 hold after last edge", ser_oe, 1);
            if (i < 15 && i > 0 && i < 3)
                chk(ser_out == w[15-i], "R5 bit held", ser_out, w[15-i]);
            repeat (4) @(negedge clk);
        end
        if (nbits == 16) chk(ser_oe == 1'b0, "R6 release after 16th edge", ser_oe, 0);
    endtask

    initial begin
        logic [15:0] got;
        logic [11:0] v, v2;
        void'($urandom(32'd1234));
        do_reset();

        // Random conversions, back to back (R1, R3, R8)
        for (int n = 0; n < 20; n++) begin
            v = 12'($urandom);
            if (n == 0) v = 12'hFFF;
            if (n == 1) v = 12'h000;
            if (n == 2) v = 12'h801;
            do_conv(v, 1'b0, 1'b0);
            read_word(16, got);
            chk(got == exp_word(v), "R3 R1 word content", got, exp_word(v));
        end
        chk(missed_req == 1'b0, "R8 no missed request in idle path", missed_req, 0);

        // Immediate restart right after busy falls (R8)
        v = 12'h3C5;
        do_conv(v, 1'b0, 1'b0);
        v2 = 12'hA5A;
        do_conv(v2, 1'b0, 1'b0);
        read_word(16, got);
        chk(got == exp_word(v2), "R8 immediate restart", got, exp_word(v2));

        // Partial read then new conversion restarts bit count (R10)
        v = 12'hFFF;
        do_conv(v, 1'b0, 1'b0);
        read_word(5, got);
        v2 = 12'hC0F;
        do_conv(v2, 1'b0, 1'b0);
        read_word(16, got);
        chk(got == exp_word(v2), "R10 restart from first bit", got, exp_word(v2));

        // Request during busy ignored (R9)
        v = 12'h123;
        do_conv(v, 1'b0, 1'b1);
        chk(missed_req == 1'b1, "R9 missed flag set", missed_req, 1);
        read_word(16, got);
        chk(got == exp_word(v), "R9 busy request ignored", got, exp_word(v));
        repeat (5) @(negedge clk);
        chk(missed_req == 1'b1, "R9 flag sticky", missed_req, 1);

        // Power-down and wake (R7)
        do_reset();
        v = 12'h5A5;
        do_conv(v, 1'b1, 1'b0);
        read_word(16, got);
        chk(got == exp_word(v), "R7 data read in sleep", got, exp_word(v));
        chk(missed_req == 1'b0, "R7 no miss before wake", missed_req, 0);
        conv_req_n = 1'b1;
        repeat (5) @(negedge clk);
        conv_req_n = 1'b0;
        repeat (6) @(negedge clk);
        chk(conv_busy == 1'b0, "R7 fall during wake starts nothing", conv_busy, 0);
        chk(missed_req == 1'b1, "R7 R9 fall during wake flagged", missed_req, 1);
        repeat (WAKE + 4) @(negedge clk);
        conv_req_n = 1'b1;
        repeat (4) @(negedge clk);
        v = 12'h9E7;
        do_conv(v, 1'b0, 1'b0);
        read_word(16, got);
        chk(got == exp_word(v), "R7 conversion after wake", got, exp_word(v));

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule